// File: doc/BRIEF.md
# Serial EEPROM Target Emulator on SPI

This block answers an SPI master in mode 0 the way a byte-addressed serial EEPROM would, with the storage held in an on-chip byte array. The array depth is a parameter and the array is split into 256-byte pages. SCK, chip select and MOSI are oversampled in the system clock domain, so SCK must run well below the system clock.

A host sets the write-enable latch with a one-byte command. It then sends a write command, a 24-bit address and data bytes. When chip select rises, the emulated write cycle starts and lasts a programmable number of system clocks. During that time the status byte shows the write as in progress. A status write changes the block-protect field, which guards the upper quarter, the upper half or the whole array. A low level on the protect pin freezes that field. A read streams data out for as long as the host keeps clocking.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is bit 0 busy (write in progress), bit 1 write-enable latch, bits 3:2 protect field, and bits 7:4 always 0. Command 0x05 returns the status byte, and repeats it on every further byte while chip select stays low.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it.
- R3: Command 0x03 followed by a 24-bit address (most significant byte first) streams array bytes from that address. Bits go out MSB first: MOSI is sampled on rising SCK and MISO changes after falling SCK. The address advances by one per byte and wraps from the last array byte to address 0.
- R4: Command 0x02 followed by a 24-bit address stores the following bytes only when the write-enable latch is set. Otherwise the array is unchanged, no busy period starts, and the latch stays clear.
- R5: Successive write bytes advance only the low 8 address bits. A write running past the end of a 256-byte page wraps to the start of that same page.
- R6: After chip select rises at the end of a write that stored at least one byte, the busy bit is set for exactly BUSY_CYC system clocks. The latch stays set during that time, and both bits clear together when it ends.
- R7: While busy, every command except 0x05 is ignored for the whole chip-select period. An ignored read returns 0x00 bytes, and an ignored write leaves the array unchanged.
- R8: The protect field selects the protected range: 00 nothing, 01 the upper quarter of the array, 10 the upper half, 11 everything. A write whose start address lies in the protected range stores nothing and clears the latch.
- R9: Command 0x01 followed by one byte, with the latch set and the protect pin high, loads that byte's bits 3:2 into the protect field and starts a busy period when chip select rises. With the latch clear it changes nothing.
- R10: With the protect pin low, a status write leaves the protect field unchanged, clears the latch and starts no busy period.
- R11: MISO is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| wp_n | input | 1 | Protect pin; low blocks status writes |
| miso | output | 1 | Serial data to the master, registered |

## Verification
The assertions assume that each SCK level lasts at least six system clocks. They also assume that SCK is low whenever chip select changes, and that the array has at least four pages, so that no page straddles a protection boundary. These assumptions guarantee that a page-wrapped write never leaves the range checked at its start address, and that status or array data is ready before the falling edge that shifts it out. The bench keeps SCK low for 40 ns and high for 40 ns (eight clocks each) and moves chip select only while SCK is low. It starts every transfer on a falling system clock edge, so no SPI edge coincides with a sampling edge of the design. It also spaces its status polls so that they fall clearly inside or clearly after a busy period.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
package ee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_SOUT, PH_SIN, PH_SKIP
  } phase_t;
endpackage

// File: rtl/ee_sync.sv
`timescale 1ns/1ps
module ee_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ee_mem.sv
`timescale 1ns/1ps
module ee_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_busy.sv
`timescale 1ns/1ps
module ee_busy #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_eeprom_emu.sv
`timescale 1ns/1ps
module spi_eeprom_emu
  import ee_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 8,
  parameter int BUSY_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  logic s_sck, s_cs_n, s_mosi, sck_q, cs_q;
  logic sck_rise, sck_fall, cs_end;

  ee_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sck, cs_n, mosi}), .q({s_sck, s_cs_n, s_mosi})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= s_sck;
      cs_q  <= s_cs_n;
    end
  end

  assign sck_rise = s_sck & ~sck_q & ~s_cs_n;
  assign sck_fall = ~s_sck & sck_q & ~s_cs_n;
  assign cs_end   = s_cs_n & ~cs_q;

  phase_t              phase;
  logic [2:0]          bcnt;
  logic [1:0]          acnt;
  logic [6:0]          rx_sr;
  logic [7:0]          byte_in, tx_sr, ld_byte, status;
  logic [ADDR_W-1:0]   addr_sr, full_addr, wr_ptr, rd_ptr;
  logic                is_wr, wr_any, sr_ok, wel, miso_q;
  logic [1:0]          bp, sr_pend;
  logic                byte_done, mem_we, busy, done, start;
  logic [7:0]          rdata;

  assign byte_in   = {rx_sr, s_mosi};
  assign byte_done = sck_rise && (bcnt == 3'd7);
  assign full_addr = {addr_sr[ADDR_W-9:0], byte_in};
  assign mem_we    = (phase == PH_WDATA) && byte_done;
  assign start     = cs_end && (((phase == PH_WDATA) && wr_any) || sr_ok);
  assign status    = {4'b0000, bp, wel, busy};
  assign ld_byte   = (phase == PH_RDATA) ? rdata : status;
  assign miso      = miso_q;

  function automatic logic is_prot(input logic [1:0] f, input logic [ADDR_W-1:0] a);
    case (f)
      2'b00:   is_prot = 1'b0;
      2'b01:   is_prot = (a[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   is_prot = a[ADDR_W-1];
      default: is_prot = 1'b1;
    endcase
  endfunction

  ee_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wr_ptr), .wdata(byte_in),
    .raddr(rd_ptr), .rdata(rdata)
  );

  ee_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD;
      bcnt    <= '0;
      acnt    <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      addr_sr <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      is_wr   <= 1'b0;
      wr_any  <= 1'b0;
      sr_ok   <= 1'b0;
      sr_pend <= '0;
      wel     <= 1'b0;
      bp      <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (done) wel <= 1'b0;
      if (s_cs_n) begin
        phase  <= PH_CMD;
        bcnt   <= '0;
        acnt   <= '0;
        wr_any <= 1'b0;
        sr_ok  <= 1'b0;
        tx_sr  <= '0;
        miso_q <= 1'b0;
        if (cs_end && sr_ok) bp <= sr_pend;
      end else begin
        if (sck_rise) begin
          bcnt  <= bcnt + 1'b1;
          rx_sr <= byte_in[6:0];
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              if (busy && byte_in != OP_RDSR) phase <= PH_SKIP;
              else begin
                case (byte_in)
                  OP_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                  OP_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                  OP_RDSR:  phase <= PH_SOUT;
                  OP_WRSR:  phase <= PH_SIN;
                  OP_READ:  begin is_wr <= 1'b0; phase <= PH_ADDR; end
                  OP_WRITE: begin is_wr <= 1'b1; phase <= PH_ADDR; end
                  default:  phase <= PH_SKIP;
                endcase
              end
            end
            PH_ADDR: begin
              addr_sr <= full_addr;
              acnt    <= acnt + 1'b1;
              if (acnt == 2'd2) begin
                if (!is_wr) begin
                  rd_ptr <= full_addr;
                  phase  <= PH_RDATA;
                end else if (wel && !is_prot(bp, full_addr)) begin
                  wr_ptr <= full_addr;
                  phase  <= PH_WDATA;
                end else begin
                  wel   <= 1'b0;
                  phase <= PH_SKIP;
                end
              end
            end
            PH_WDATA: begin
              wr_ptr[PAGE_W-1:0] <= wr_ptr[PAGE_W-1:0] + 1'b1;
              wr_any <= 1'b1;
            end
            PH_SIN: begin
              if (wel && wp_n) begin
                sr_ok   <= 1'b1;
                sr_pend <= byte_in[3:2];
              end else begin
                wel <= 1'b0;
              end
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall) begin
          if (bcnt == 3'd0 && (phase == PH_RDATA || phase == PH_SOUT)) begin
            miso_q <= ld_byte[7];
            tx_sr  <= {ld_byte[6:0], 1'b0};
            if (phase == PH_RDATA) rd_ptr <= rd_ptr + 1'b1;
          end else begin
            miso_q <= tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/ee_chk.sv
`timescale 1ns/1ps
module ee_chk #(
  parameter int ADDR_W   = 10,
  parameter int BUSY_CYC = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wel,
  input logic [1:0]        bp,
  input logic              mem_we,
  input logic [ADDR_W-1:0] waddr,
  input logic              cs_q,
  input logic              miso
);
  int unsigned busy_cnt;
  logic        in_prot;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  always_comb begin
    case (bp)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = waddr[ADDR_W-1] & waddr[ADDR_W-2];
      2'b10:   in_prot = waddr[ADDR_W-1];
      default: in_prot = 1'b1;
    endcase
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_cnt == BUSY_CYC);

  // R6
  wel_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R7
  busy_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !busy);

  // R8
  prot_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !in_prot);

  // R9
  bp_chg_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> $rose(busy));

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> !miso);
endmodule

bind spi_eeprom_emu ee_chk #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wel(wel), .bp(bp), .mem_we(mem_we),
  .waddr(wr_ptr), .cs_q(cs_q), .miso(miso)
);

// File: tb/spi_eeprom_emu_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_emu_tb_top;
  localparam int AW   = 10;
  localparam int BUSY = 2000;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;

  always #2.5 clk = ~clk;

  spi_eeprom_emu #(.ADDR_W(AW), .PAGE_W(8), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n), .miso(miso)
  );

  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // scoreboard monitor
  initial begin
    logic [7:0] g, e;
    string t;
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        g = got_q.pop_front();
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected byte: actual %02h expected none", g);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (g !== e) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", t, g, e);
          end
        end
      end
    end
  end

  task automatic expect_b(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] v, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = v[i];
      #40;
      sck  = 1'b1;
      r[i] = miso;
      #40;
      sck  = 1'b0;
    end
  endtask

  task automatic xfer(input int n_rd);
    logic [7:0] r;
    @(negedge clk);
    cs_n = 1'b0;
    #40;
    while (tx_q.size() > 0) spi_byte(tx_q.pop_front(), r);
    for (int k = 0; k < n_rd; k++) begin
      spi_byte(8'h00, r);
      got_q.push_back(r);
    end
    #40;
    cs_n = 1'b1;
    #100;
  endtask

  task automatic cmd1(input logic [7:0] op);
    tx_q.push_back(op);
    xfer(0);
  endtask

  task automatic rdsr(input logic [7:0] v, input string t);
    expect_b(v, t);
    tx_q.push_back(8'h05);
    xfer(1);
  endtask

  task automatic put_addr(input logic [7:0] op, input logic [23:0] a);
    tx_q.push_back(op);
    tx_q.push_back(a[23:16]);
    tx_q.push_back(a[15:8]);
    tx_q.push_back(a[7:0]);
  endtask

  task automatic wr1(input logic [23:0] a, input logic [7:0] d);
    put_addr(8'h02, a);
    tx_q.push_back(d);
    xfer(0);
  endtask

  task automatic rd1(input logic [23:0] a, input logic [7:0] v, input string t);
    expect_b(v, t);
    put_addr(8'h03, a);
    xfer(1);
  endtask

  task automatic wrsr(input logic [7:0] d);
    tx_q.push_back(8'h01);
    tx_q.push_back(d);
    xfer(0);
  endtask

  task automatic wait_idle();
    repeat (BUSY + 200) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #900us;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    chk("R11 idle miso", {7'd0, miso}, 8'h00);
    rdsr(8'h00, "R1 status after reset");
    cmd1(8'h06);
    rdsr(8'h02, "R2 latch set");
    cmd1(8'h04);
    rdsr(8'h00, "R2 latch cleared");

    // first write, then commands during busy
    cmd1(8'h06);
    put_addr(8'h02, 24'h000000);
    tx_q.push_back(8'h11); tx_q.push_back(8'h22);
    tx_q.push_back(8'h33); tx_q.push_back(8'h44);
    xfer(0);
    rdsr(8'h03, "R6 busy with latch held");
    cmd1(8'h04);
    rdsr(8'h03, "R7 latch clear ignored while busy");
    wr1(24'h000002, 8'h55);
    rd1(24'h000000, 8'h00, "R7 read ignored while busy");
    wait_idle();
    rdsr(8'h00, "R6 busy and latch cleared");
    chk("R11 idle miso after txn", {7'd0, miso}, 8'h00);
    expect_b(8'h11, "R3 stream byte 0");
    expect_b(8'h22, "R3 stream byte 1");
    expect_b(8'h33, "R7 byte untouched by busy write");
    expect_b(8'h44, "R3 stream byte 3");
    put_addr(8'h03, 24'h000000);
    xfer(4);

    // write without latch
    wr1(24'h000001, 8'h99);
    rdsr(8'h00, "R4 no busy on rejected write");
    rd1(24'h000001, 8'h22, "R4 array unchanged");

    // page wrap
    cmd1(8'h06);
    put_addr(8'h02, 24'h0001FE);
    tx_q.push_back(8'hA0); tx_q.push_back(8'hA1);
    tx_q.push_back(8'hA2); tx_q.push_back(8'hA3);
    xfer(0);
    wait_idle();
    expect_b(8'hA0, "R5 page byte 254");
    expect_b(8'hA1, "R5 page byte 255");
    put_addr(8'h03, 24'h0001FE);
    xfer(2);
    expect_b(8'hA2, "R5 wrapped to page start");
    expect_b(8'hA3, "R5 wrapped second byte");
    put_addr(8'h03, 24'h000100);
    xfer(2);

    // read wraps at end of array
    cmd1(8'h06);
    wr1(24'h0003FF, 8'h5A);
    wait_idle();
    expect_b(8'h5A, "R3 last array byte");
    expect_b(8'h11, "R3 wrap to address 0");
    put_addr(8'h03, 24'h0003FF);
    xfer(2);

    // protect upper quarter
    cmd1(8'h06);
    wrsr(8'h04);
    rdsr(8'h07, "R9 status write busy");
    wait_idle();
    rdsr(8'h04, "R9 field loaded");
    cmd1(8'h06);
    wr1(24'h0003FF, 8'hEE);
    rdsr(8'h04, "R8 rejected write clears latch");
    rd1(24'h0003FF, 8'h5A, "R8 quarter protected");
    cmd1(8'h06);
    wr1(24'h000200, 8'h77);
    wait_idle();
    rd1(24'h000200, 8'h77, "R8 below quarter writable");

    // protect upper half
    cmd1(8'h06);
    wrsr(8'h08);
    wait_idle();
    rdsr(8'h08, "R9 half field");
    cmd1(8'h06);
    wr1(24'h000200, 8'h00);
    rd1(24'h000200, 8'h77, "R8 half protected");
    cmd1(8'h06);
    wr1(24'h0001FF, 8'h3C);
    wait_idle();
    rd1(24'h0001FF, 8'h3C, "R8 lower half writable");

    // protect all
    cmd1(8'h06);
    wrsr(8'h0C);
    wait_idle();
    rdsr(8'h0C, "R9 full field");
    cmd1(8'h06);
    wr1(24'h000000, 8'hFF);
    rd1(24'h000000, 8'h11, "R8 whole array protected");

    // protect pin low
    wp_n = 1'b0;
    cmd1(8'h06);
    rdsr(8'h0E, "R10 latch set with pin low");
    wrsr(8'h00);
    rdsr(8'h0C, "R10 status write blocked");
    wp_n = 1'b1;
    cmd1(8'h06);
    wrsr(8'h00);
    wait_idle();
    rdsr(8'h00, "R9 field cleared with pin high");
    wrsr(8'h0C);
    rdsr(8'h00, "R9 no change without latch");

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule